// File: doc/BRIEF.md
# SDRAM Multi-Bank Page Tracker

This block sits between a request splitter and an SDRAM transfer engine. Each incoming sub-request names a bank, a row, a column, a length and a direction. The block remembers which row is open in each of four banks and turns each sub-request into the right SDRAM command sequence:

- When the row is already open (a page hit), it sends a read or write command at once.
- When the bank is closed, it sends activate first and then the read or write.
- When a different row is open, it sends precharge, then activate, then the read or write.

Each bank holds one pending sub-request and has its own timers for the active-to-precharge, precharge-to-active and active-to-access delays. A request to a busy bank therefore never holds up the other banks. A per-request close flag makes the bank precharge right after its access, which suits the end of a DMA stream. While the transfer engine signals a refresh, every bank is treated as closed and no activate goes out. The transfer engine gates each command class with its own "ok" inputs, and it takes each command with a handshake.

Top module: `sdram_page_tracker`

## Requirements
- R1: While reset is high and in the first cycle after it, `cmd_vld` is 0 and `idle` is 1. With `cfg_depth`=0 and no requests pending, `req_rdy` is 1.
- R2: A request to a closed bank produces activate (code 01) with `cmd_addr` = row. It is followed by a read (code 10) or a write (code 11) with `cmd_addr` = column and `cmd_len` = length.
- R3: A request whose row equals the open row of its bank produces a single read or write and no precharge (code 00) or activate.
- R4: A request to a bank that has a different row open produces precharge, then activate of the new row, then the access.
- R5: A read or write follows the activate of its bank by no fewer than `cfg_trcd`+1 cycles. It follows by exactly that many when nothing else holds it back.
- R6: A precharge follows the activate of its bank by no fewer than `cfg_tras`+1 cycles. It follows by exactly that many when nothing else holds it back.
- R7: An activate follows the precharge of its bank by no fewer than `cfg_trp`+1 cycles. It follows by exactly that many when nothing else holds it back.
- R8: A request is accepted (`req_vld` and `req_rdy` both high) only when its bank holds no pending request and fewer than `cfg_depth`+1 requests are pending.
- R9: A request accepted with `req_close`=1 is followed by a precharge of its bank once `cfg_tras` allows. A later request to the same row then sees a closed bank and gets an activate.
- R10: Precharge of bank b needs `pre_ok[b]`, activate needs `act_ok`, read needs `rd_ok` and write needs `wr_ok`. No command of a class goes out while its enable is low.
- R11: While `refresh` is high, no activate is issued and every bank is marked closed. A request to a previously open row therefore gets an activate after `refresh` falls.
- R12: `idle` is 1 exactly when no bank holds a pending request, including a pending close.
- R13: A presented command stays on `cmd_vld`/`cmd_code`/`cmd_bank`/`cmd_addr`/`cmd_len`, unchanged, until `cmd_ack` is high. Only a lower-numbered bank that is ready wins over a higher one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_depth | input | 2 | Maximum pending requests minus one |
| cfg_tras | input | 4 | Activate-to-precharge delay in cycles |
| cfg_trp | input | 4 | Precharge-to-activate delay in cycles |
| cfg_trcd | input | 4 | Activate-to-access delay in cycles |
| req_vld | input | 1 | Sub-request valid |
| req_rdy | output | 1 | Sub-request can be accepted this cycle |
| req_bank | input | 2 | Target bank |
| req_row | input | 12 | Target row |
| req_col | input | 12 | Start column |
| req_len | input | 8 | Transfer length |
| req_wr | input | 1 | 1 write, 0 read |
| req_close | input | 1 | Precharge the bank after this access |
| cmd_vld | output | 1 | Command to transfer engine valid |
| cmd_code | output | 2 | 00 precharge, 01 activate, 10 read, 11 write |
| cmd_bank | output | 2 | Command bank |
| cmd_addr | output | 12 | Row for activate, column for access, 0 for precharge |
| cmd_len | output | 8 | Length for access commands |
| cmd_ack | input | 1 | Transfer engine takes the command |
| pre_ok | input | 4 | Per-bank precharge allowed |
| act_ok | input | 1 | Activate allowed |
| rd_ok | input | 1 | Read allowed |
| wr_ok | input | 1 | Write allowed |
| refresh | input | 1 | Refresh in progress |
| idle | output | 1 | No pending request in any bank |

## Verification
The page lookup is tried with three request patterns: a closed bank, the open row, and a different open row. The resulting command streams (activate+access, access alone, precharge+activate+access) tell a wrong hit test apart from a wrong open-row update. Delay settings of different sizes are used in bursts whose issue cycles are measured. This separates an off-by-one in each timer and shows which timer gates which command. A sequence of a close-flagged request followed by a refresh window shows that both paths leave the bank closed. Holding the enables or the acknowledge low, with the depth set small, shows that requests queue per bank and that commands stay frozen until they are taken.

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef enum logic [1:0] {
    CMD_PRE = 2'b00,
    CMD_ACT = 2'b01,
    CMD_RD  = 2'b10,
    CMD_WR  = 2'b11
  } pt_cmd_e;
endpackage

// File: rtl/pt_bank_slot.sv
// One bank: pending request, open-row state and its three delay timers.
module pt_bank_slot
  import pt_pkg::*;
#(
  parameter int AW    = 12,
  parameter int LEN_W = 8,
  parameter int TMR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TMR_W-1:0] tras_cfg,
  input  logic [TMR_W-1:0] trp_cfg,
  input  logic [TMR_W-1:0] trcd_cfg,
  input  logic             load,
  input  logic [AW-1:0]    ld_row,
  input  logic [AW-1:0]    ld_col,
  input  logic [LEN_W-1:0] ld_len,
  input  logic             ld_wr,
  input  logic             ld_close,
  input  logic             issue,
  input  logic             refresh,
  input  logic             pre_ok,
  input  logic             act_ok,
  input  logic             rd_ok,
  input  logic             wr_ok,
  output logic             busy,
  output logic             can_go,
  output pt_cmd_e          want,
  output logic [AW-1:0]    want_addr,
  output logic [LEN_W-1:0] want_len
);
  logic             vld, closing, open, wr, cls;
  logic [AW-1:0]    row, col, open_row;
  logic [LEN_W-1:0] len;
  logic [TMR_W-1:0] tras_c, trp_c, trcd_c;
  logic             hit, drop;

  assign busy     = vld;
  assign hit      = open && (open_row == row);
  assign drop     = vld && closing && !open;
  assign want_len = len;

  always_comb begin
    want      = CMD_PRE;
    want_addr = '0;
    can_go    = 1'b0;
    if (vld) begin
      if (closing) begin
        want   = CMD_PRE;
        can_go = open && (tras_c == '0) && pre_ok;
      end else if (hit) begin
        want      = wr ? CMD_WR : CMD_RD;
        want_addr = col;
        can_go    = (trcd_c == '0) && (wr ? wr_ok : rd_ok);
      end else if (open) begin
        want   = CMD_PRE;
        can_go = (tras_c == '0) && pre_ok;
      end else begin
        want      = CMD_ACT;
        want_addr = row;
        can_go    = (trp_c == '0) && act_ok && !refresh;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld      <= 1'b0;
      closing  <= 1'b0;
      open     <= 1'b0;
      wr       <= 1'b0;
      cls      <= 1'b0;
      row      <= '0;
      col      <= '0;
      len      <= '0;
      open_row <= '0;
      tras_c   <= '0;
      trp_c    <= '0;
      trcd_c   <= '0;
    end else begin
      if (tras_c != '0) tras_c <= tras_c - 1'b1;
      if (trp_c  != '0) trp_c  <= trp_c  - 1'b1;
      if (trcd_c != '0) trcd_c <= trcd_c - 1'b1;
      if (load) begin
        vld     <= 1'b1;
        closing <= 1'b0;
        row     <= ld_row;
        col     <= ld_col;
        len     <= ld_len;
        wr      <= ld_wr;
        cls     <= ld_close;
      end
      if (drop) vld <= 1'b0;
      if (issue) begin
        unique case (want)
          CMD_PRE: begin
            open  <= 1'b0;
            trp_c <= trp_cfg;
            if (closing) vld <= 1'b0;
          end
          CMD_ACT: begin
            open     <= 1'b1;
            open_row <= row;
            tras_c   <= tras_cfg;
            trcd_c   <= trcd_cfg;
          end
          default: begin
            if (cls) closing <= 1'b1;
            else     vld     <= 1'b0;
          end
        endcase
      end
      if (refresh) open <= 1'b0;
    end
  end
endmodule

// File: rtl/pt_pick.sv
// Fixed priority: the lowest-numbered ready bank wins.
module pt_pick #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        idx    = IW'(i);
        any    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdram_page_tracker.sv
module sdram_page_tracker
  import pt_pkg::*;
#(
  parameter int NB    = 4,
  parameter int AW    = 12,
  parameter int LEN_W = 8,
  parameter int TMR_W = 4,
  parameter int DEP_W = 2,
  localparam int BA_W = $clog2(NB),
  localparam int CNT_W = $clog2(NB + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DEP_W-1:0] cfg_depth,
  input  logic [TMR_W-1:0] cfg_tras,
  input  logic [TMR_W-1:0] cfg_trp,
  input  logic [TMR_W-1:0] cfg_trcd,
  input  logic             req_vld,
  output logic             req_rdy,
  input  logic [BA_W-1:0]  req_bank,
  input  logic [AW-1:0]    req_row,
  input  logic [AW-1:0]    req_col,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_wr,
  input  logic             req_close,
  output logic             cmd_vld,
  output logic [1:0]       cmd_code,
  output logic [BA_W-1:0]  cmd_bank,
  output logic [AW-1:0]    cmd_addr,
  output logic [LEN_W-1:0] cmd_len,
  input  logic             cmd_ack,
  input  logic [NB-1:0]    pre_ok,
  input  logic             act_ok,
  input  logic             rd_ok,
  input  logic             wr_ok,
  input  logic             refresh,
  output logic             idle
);
  logic [NB-1:0]    busy, ready, gnt, issue, load;
  pt_cmd_e          want_a [NB];
  logic [AW-1:0]    addr_a [NB];
  logic [LEN_W-1:0] len_a  [NB];
  logic [BA_W-1:0]  sel;
  logic             any, adv;
  logic [CNT_W-1:0] pend;

  always_comb begin
    pend = '0;
    for (int i = 0; i < NB; i++) pend = pend + CNT_W'(busy[i]);
  end

  assign req_rdy = !busy[req_bank] && (pend <= CNT_W'(cfg_depth));
  assign adv     = !cmd_vld || cmd_ack;
  assign issue   = adv ? gnt : '0;
  assign idle    = ~|busy;

  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_bank
      assign load[b] = req_vld && req_rdy && (req_bank == BA_W'(b));
      pt_bank_slot #(.AW(AW), .LEN_W(LEN_W), .TMR_W(TMR_W)) u_slot (
        .clk(clk), .rst(rst),
        .tras_cfg(cfg_tras), .trp_cfg(cfg_trp), .trcd_cfg(cfg_trcd),
        .load(load[b]), .ld_row(req_row), .ld_col(req_col), .ld_len(req_len),
        .ld_wr(req_wr), .ld_close(req_close),
        .issue(issue[b]), .refresh(refresh), .pre_ok(pre_ok[b]),
        .act_ok(act_ok), .rd_ok(rd_ok), .wr_ok(wr_ok),
        .busy(busy[b]), .can_go(ready[b]), .want(want_a[b]),
        .want_addr(addr_a[b]), .want_len(len_a[b])
      );
    end
  endgenerate

  pt_pick #(.N(NB), .IW(BA_W)) u_pick (
    .req(ready), .gnt(gnt), .idx(sel), .any(any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_vld  <= 1'b0;
      cmd_code <= '0;
      cmd_bank <= '0;
      cmd_addr <= '0;
      cmd_len  <= '0;
    end else if (adv) begin
      cmd_vld <= any;
      if (any) begin
        cmd_code <= want_a[sel];
        cmd_bank <= sel;
        cmd_addr <= addr_a[sel];
        cmd_len  <= len_a[sel];
      end
    end
  end
endmodule

// File: rtl/pt_checker.sv
module pt_checker #(
  parameter int NB   = 4,
  parameter int AW   = 12,
  parameter int BA_W = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            cmd_vld,
  input logic            cmd_ack,
  input logic [1:0]      cmd_code,
  input logic [BA_W-1:0] cmd_bank,
  input logic [AW-1:0]   cmd_addr,
  input logic            act_ok,
  input logic            rd_ok,
  input logic            refresh,
  input logic            req_vld,
  input logic            req_rdy,
  input logic [BA_W-1:0] req_bank,
  input logic [NB-1:0]   busy,
  input logic            idle
);
  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!cmd_vld && idle));

  // R13
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld && !cmd_ack) |=> (cmd_vld && $stable(cmd_code) && $stable(cmd_bank) && $stable(cmd_addr)));

  // R10
  act_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld && (!$past(cmd_vld) || $past(cmd_ack)) && cmd_code == 2'b01) |-> $past(act_ok));

  // R10
  rd_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld && (!$past(cmd_vld) || $past(cmd_ack)) && cmd_code == 2'b10) |-> $past(rd_ok));

  // R11
  rfsh_act_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld && (!$past(cmd_vld) || $past(cmd_ack)) && cmd_code == 2'b01) |-> !$past(refresh));

  // R8
  accept_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (req_vld && req_rdy) |=> busy[$past(req_bank)]);

  // R12
  idle_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (idle && !(req_vld && req_rdy)) |=> idle);
endmodule

bind sdram_page_tracker pt_checker #(.NB(NB), .AW(AW), .BA_W(BA_W)) u_pt_chk (
  .clk(clk), .rst(rst), .cmd_vld(cmd_vld), .cmd_ack(cmd_ack), .cmd_code(cmd_code),
  .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .act_ok(act_ok), .rd_ok(rd_ok),
  .refresh(refresh), .req_vld(req_vld), .req_rdy(req_rdy), .req_bank(req_bank),
  .busy(busy), .idle(idle)
);

// File: tb/test_sdram_page_tracker.sv
`timescale 1ns/1ps
module test_sdram_page_tracker;
  localparam int PRE = 0, ACT = 1, RD = 2, WR = 3;

  logic        clk = 0;
  logic        rst = 1;
  logic [1:0]  cfg_depth = 3;
  logic [3:0]  cfg_tras = 5, cfg_trp = 2, cfg_trcd = 3;
  logic        req_vld = 0, req_wr = 0, req_close = 0;
  logic        req_rdy;
  logic [1:0]  req_bank = 0;
  logic [11:0] req_row = 0, req_col = 0;
  logic [7:0]  req_len = 0;
  logic        cmd_vld, cmd_ack = 1;
  logic [1:0]  cmd_code, cmd_bank;
  logic [11:0] cmd_addr;
  logic [7:0]  cmd_len;
  logic [3:0]  pre_ok = 4'hF;
  logic        act_ok = 1, rd_ok = 1, wr_ok = 1, refresh = 0;
  logic        idle;

  int n_chk = 0, n_fail = 0, cyc = 0, log_n = 0;
  int lg_cmd [0:63];
  int lg_bank[0:63];
  int lg_addr[0:63];
  int lg_len [0:63];
  int lg_cyc [0:63];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && cmd_vld && cmd_ack && log_n < 64) begin
      lg_cmd[log_n]  <= int'(cmd_code);
      lg_bank[log_n] <= int'(cmd_bank);
      lg_addr[log_n] <= int'(cmd_addr);
      lg_len[log_n]  <= int'(cmd_len);
      lg_cyc[log_n]  <= cyc;
      log_n          <= log_n + 1;
    end
  end

  sdram_page_tracker i_sdram_page_tracker (
    .clk(clk), .rst(rst), .cfg_depth(cfg_depth), .cfg_tras(cfg_tras),
    .cfg_trp(cfg_trp), .cfg_trcd(cfg_trcd), .req_vld(req_vld), .req_rdy(req_rdy),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_len(req_len),
    .req_wr(req_wr), .req_close(req_close), .cmd_vld(cmd_vld), .cmd_code(cmd_code),
    .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_ack(cmd_ack),
    .pre_ok(pre_ok), .act_ok(act_ok), .rd_ok(rd_ok), .wr_ok(wr_ok),
    .refresh(refresh), .idle(idle)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic ent(input int i, input int c, input int bk, input int ad, input string tag);
    chk(lg_cmd[i] == c,   tag, "cmd code", lg_cmd[i], c);
    chk(lg_bank[i] == bk, tag, "cmd bank", lg_bank[i], bk);
    chk(lg_addr[i] == ad, tag, "cmd addr", lg_addr[i], ad);
  endtask

  task automatic wait_log(input int n, input string tag);
    int k = 0;
    while (log_n < n && k < 200) begin
      @(negedge clk);
      k++;
    end
    chk(log_n >= n, tag, "commands logged", log_n, n);
  endtask

  task automatic send(input int bk, input int row, input int col, input int len,
                      input bit wr, input bit cls);
    @(negedge clk);
    req_bank = 2'(bk); req_row = 12'(row); req_col = 12'(col);
    req_len = 8'(len); req_wr = wr; req_close = cls; req_vld = 1;
    #1;
    while (!req_rdy) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    req_vld = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(cmd_vld == 0, "R1", "cmd_vld in reset", cmd_vld, 0);
    chk(idle == 1, "R1", "idle in reset", idle, 1);
    rst = 0;
    cfg_depth = 0;
    @(negedge clk);
    chk(cmd_vld == 0, "R1", "cmd_vld after reset", cmd_vld, 0);
    chk(req_rdy == 1, "R1", "req_rdy after reset", req_rdy, 1);
    cfg_depth = 3;
  endtask

  task automatic t_miss_closed;
    int b0 = log_n;
    send(0, 'h12, 'h34, 8, 0, 0);
    wait_log(b0 + 2, "R2");
    ent(b0, ACT, 0, 'h12, "R2");
    ent(b0 + 1, RD, 0, 'h34, "R2");
    chk(lg_len[b0 + 1] == 8, "R2", "read length", lg_len[b0 + 1], 8);
    chk(lg_cyc[b0 + 1] - lg_cyc[b0] == 4, "R5", "act to read gap", lg_cyc[b0 + 1] - lg_cyc[b0], 4);
  endtask

  task automatic t_hit;
    int b0 = log_n;
    send(0, 'h12, 'h40, 2, 1, 0);
    wait_log(b0 + 1, "R3");
    repeat (20) @(negedge clk);
    chk(log_n == b0 + 1, "R3", "commands for hit", log_n - b0, 1);
    ent(b0, WR, 0, 'h40, "R3");
  endtask

  task automatic t_miss_open;
    int b0 = log_n;
    send(0, 'h99, 'h3, 4, 0, 0);
    wait_log(b0 + 3, "R4");
    ent(b0, PRE, 0, 0, "R4");
    ent(b0 + 1, ACT, 0, 'h99, "R4");
    ent(b0 + 2, RD, 0, 'h3, "R4");
    chk(lg_cyc[b0 + 1] - lg_cyc[b0] == 3, "R7", "pre to act gap", lg_cyc[b0 + 1] - lg_cyc[b0], 3);
  endtask

  task automatic t_close;
    int b0 = log_n;
    cfg_tras = 9;
    send(1, 5, 7, 1, 0, 1);
    wait_log(b0 + 3, "R9");
    ent(b0, ACT, 1, 5, "R9");
    ent(b0 + 1, RD, 1, 7, "R9");
    ent(b0 + 2, PRE, 1, 0, "R9");
    chk(lg_cyc[b0 + 2] - lg_cyc[b0] == 10, "R6", "act to pre gap", lg_cyc[b0 + 2] - lg_cyc[b0], 10);
    send(1, 5, 8, 1, 0, 0);
    wait_log(b0 + 5, "R9");
    ent(b0 + 3, ACT, 1, 5, "R9");
    ent(b0 + 4, RD, 1, 8, "R9");
    cfg_tras = 5;
  endtask

  task automatic t_depth_gate;
    int b0 = log_n;
    cfg_depth = 1;
    act_ok = 0;
    rd_ok = 0;
    send(2, 'h21, 1, 1, 0, 0);
    send(3, 'h31, 2, 1, 0, 0);
    @(negedge clk);
    req_bank = 0; req_row = 1; req_vld = 1;
    #1;
    chk(req_rdy == 0, "R8", "rdy past depth", req_rdy, 0);
    req_vld = 0;
    cfg_depth = 3;
    req_bank = 2;
    #1;
    chk(req_rdy == 0, "R8", "rdy same bank busy", req_rdy, 0);
    req_bank = 0;
    #1;
    chk(req_rdy == 1, "R8", "rdy free bank", req_rdy, 1);
    chk(idle == 0, "R12", "idle while pending", idle, 0);
    repeat (10) @(negedge clk);
    chk(log_n == b0, "R10", "commands with act_ok low", log_n - b0, 0);
    act_ok = 1;
    repeat (10) @(negedge clk);
    chk(log_n == b0 + 2, "R10", "commands with rd_ok low", log_n - b0, 2);
    ent(b0, ACT, 2, 'h21, "R13");
    ent(b0 + 1, ACT, 3, 'h31, "R10");
    rd_ok = 1;
    wait_log(b0 + 4, "R10");
    ent(b0 + 2, RD, 2, 1, "R10");
    ent(b0 + 3, RD, 3, 2, "R10");
    @(negedge clk);
    chk(idle == 1, "R12", "idle after drain", idle, 1);
  endtask

  task automatic t_hold;
    int b0 = log_n;
    logic [1:0] c0, k0;
    logic [11:0] a0;
    cmd_ack = 0;
    send(3, 'h31, 5, 4, 1, 0);
    while (!cmd_vld) @(negedge clk);
    c0 = cmd_code; k0 = cmd_bank; a0 = cmd_addr;
    repeat (5) @(negedge clk);
    chk(cmd_vld == 1, "R13", "held valid", cmd_vld, 1);
    chk(cmd_code == c0 && cmd_bank == k0 && cmd_addr == a0, "R13", "held fields",
        int'(cmd_addr), int'(a0));
    cmd_ack = 1;
    wait_log(b0 + 1, "R13");
    ent(b0, WR, 3, 5, "R13");
    chk(lg_len[b0] == 4, "R13", "write length", lg_len[b0], 4);
  endtask

  task automatic t_refresh;
    int b0 = log_n;
    @(negedge clk);
    refresh = 1;
    send(0, 'h99, 1, 1, 0, 0);
    repeat (8) @(negedge clk);
    chk(log_n == b0, "R11", "commands during refresh", log_n - b0, 0);
    refresh = 0;
    wait_log(b0 + 2, "R11");
    ent(b0, ACT, 0, 'h99, "R11");
    ent(b0 + 1, RD, 0, 1, "R11");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_miss_closed();
    t_hit();
    t_miss_open();
    t_close();
    t_depth_gate();
    t_hold();
    t_refresh();
    repeat (5) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule